// File: doc/BRIEF.md
# PCM Serial Receive Port

This block takes one 8-bit companded voice sample per frame from a serial time-slot highway and hands it to the core as a parallel byte with a one-cycle valid strobe. All pins are sampled by a fast system clock. The master clock, the receive data clock, the frame sync and the serial data are synchronized and edge-detected in that clock domain. Bits are taken on falling edges of whichever bit clock is active.

A static mode input picks one of two timings. In fixed-rate timing the master clock is also the bit clock. A rising frame sync starts a word, and the next eight master-clock falling edges are captured whatever the sync level does after that. In variable-rate timing a separate receive data clock carries the bits. The frame sync then acts as a slot enable: bits are taken only while it is high, and a slot that closes early throws the partial word away.

When the frame sync stays low for a programmable number of system cycles (30 ms by default), the channel goes to standby and captures nothing. The next frame-sync rising edge wakes it. That waking slot is skipped, and capture resumes with the slot after it.

Top module: `pcm_rx_port`

## Requirements
- R1: After reset, word_o is 8'h00, word_vld_o is 0 and standby_o is 0.
- R2: With mode_i = 0 (fixed rate), a frame-sync rising edge starts a word. The next eight falling edges of mclk_i shift in sdata_i, and the first bit taken lands in word_o[7] (MSB first). The result then appears on word_o together with word_vld_o.
- R3: word_vld_o is high for exactly one system cycle per completed word, and word_o holds its value until the next completed word.
- R4: In fixed-rate mode the frame sync may fall after the word has started; the word still completes.
- R5: With mode_i = 1 (variable rate), bits are taken on falling edges of dclk_i only while fsync_i is high; mclk_i edges are ignored.
- R6: In variable-rate mode, if fsync_i falls before the eighth bit, no valid is raised and word_o keeps its previous value.
- R7: Once eight bits are taken in a slot, further bit-clock falling edges are ignored until the next frame-sync rising edge, so there is exactly one valid per slot.
- R8: In fixed-rate mode, dclk_i edges are ignored.
- R9: standby_o rises after IDLE_CYCLES consecutive system cycles with the synchronized frame sync low. Any high frame sync restarts this count.
- R10: A frame-sync rising edge clears standby_o. The slot that woke the channel is not captured, no valid is raised during standby, and the following slot is captured normally.
- R11: A bit-clock falling edge seen in the same system cycle as the frame-sync rising edge is not counted as a bit; capture starts with the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 1 | Timing select: 0 fixed rate, 1 variable rate (static) |
| mclk_i | input | 1 | Master clock; bit clock in fixed-rate mode |
| dclk_i | input | 1 | Receive data clock for variable-rate mode |
| fsync_i | input | 1 | Frame sync / receive slot enable |
| sdata_i | input | 1 | Serial PCM data, MSB first |
| word_o | output | 8 | Last completed received word |
| word_vld_o | output | 1 | One-cycle strobe when word_o updates |
| standby_o | output | 1 | Receive channel in standby |

## Verification
Leaving standby and starting a word are both triggered by the same frame-sync rising edge, so they fall in one cycle. The bench holds the frame sync low past the idle limit and then sends a complete variable-rate slot. It expects standby to clear, no strobe, an unchanged word, and a correct capture of the slot after it. A second coincidence, a bit-clock fall in the same cycle as the sync rise, is set up by switching both pins together with a marker bit on the data line. A wrongly counted edge would shift that marker into the MSB.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

  localparam int unsigned PCM_BITS = 8;

  typedef enum logic {
    RX_FIXED    = 1'b0,
    RX_VARIABLE = 1'b1
  } rx_mode_e;

  // Pin bundle carried through the synchronizer, one bit per line.
  typedef struct packed {
    logic mclk;
    logic dclk;
    logic fs;
    logic sd;
  } rx_lines_t;

endpackage

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;
    logic              prev_q;

    always_comb chain_d = {chain_q[STAGES-2:0], raw_i[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= chain_d;
        prev_q  <= chain_q[STAGES-1];
      end
    end

    assign lvl_o[g]  = chain_q[STAGES-1];
    assign rise_o[g] = chain_q[STAGES-1] & ~prev_q;
    assign fall_o[g] = ~chain_q[STAGES-1] & prev_q;
  end

endmodule

// File: rtl/pcm_rx_idle.sv
module pcm_rx_idle #(
  parameter int unsigned IDLE_CYCLES = 3_750_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fs_lvl_i,
  input  logic fs_rise_i,
  output logic standby_o
);

  localparam int unsigned CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT    = CW'(IDLE_CYCLES);
  localparam logic [CW-1:0] LIMIT_M1 = CW'(IDLE_CYCLES - 1);

  logic [CW-1:0] low_cnt_q, low_cnt_d;
  logic          standby_q, standby_d;

  always_comb begin
    low_cnt_d = low_cnt_q;
    standby_d = standby_q;
    if (fs_lvl_i) begin
      low_cnt_d = '0;
    end else if (low_cnt_q != LIMIT) begin
      low_cnt_d = low_cnt_q + 1'b1;
    end
    if (fs_rise_i) begin
      standby_d = 1'b0;
    end else if (!fs_lvl_i && low_cnt_q == LIMIT_M1) begin
      standby_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q <= '0;
      standby_q <= 1'b0;
    end else begin
      low_cnt_q <= low_cnt_d;
      standby_q <= standby_d;
    end
  end

  assign standby_o = standby_q;

  // R9
  standby_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(standby_q) |-> $past(!fs_lvl_i));

  // R10
  standby_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(standby_q) |-> $past(fs_rise_i));

endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift
  import pcm_rx_pkg::*;
#(
  parameter int unsigned WORD_BITS = PCM_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  rx_mode_e             mode_i,
  input  logic                 fs_lvl_i,
  input  logic                 fs_rise_i,
  input  logic                 bclk_fall_i,
  input  logic                 sd_i,
  input  logic                 standby_i,
  output logic [WORD_BITS-1:0] word_o,
  output logic                 vld_o
);

  localparam int unsigned CNT_W = $clog2(WORD_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS - 1);

  logic                 armed_q, armed_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [WORD_BITS-1:0] sreg_q, sreg_d;
  logic [WORD_BITS-1:0] word_q, word_d;
  logic                 vld_q, vld_d;

  logic start, gate_ok, shift_en, abort;

  always_comb begin
    start    = fs_rise_i & ~standby_i;
    gate_ok  = (mode_i == RX_FIXED) | fs_lvl_i;
    shift_en = armed_q & bclk_fall_i & gate_ok & ~start & ~standby_i;
    abort    = armed_q & (~gate_ok | standby_i);

    armed_d = armed_q;
    cnt_d   = cnt_q;
    sreg_d  = sreg_q;
    word_d  = word_q;
    vld_d   = 1'b0;

    if (start) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (abort) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (shift_en) begin
      sreg_d = {sreg_q[WORD_BITS-2:0], sd_i};
      if (cnt_q == LAST) begin
        armed_d = 1'b0;
        cnt_d   = '0;
        word_d  = sreg_d;
        vld_d   = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      sreg_q  <= '0;
      word_q  <= '0;
      vld_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      sreg_q  <= sreg_d;
      word_q  <= word_d;
      vld_q   <= vld_d;
    end
  end

  assign word_o = word_q;
  assign vld_o  = vld_q;

  // R3
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

  // R3
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> $stable(word_q));

  // R7
  slot_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> !armed_q);

  // R6
  var_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && mode_i == RX_VARIABLE) |-> $past(fs_lvl_i));

endmodule

// File: rtl/pcm_rx_port.sv
module pcm_rx_port
  import pcm_rx_pkg::*;
#(
  parameter int unsigned WORD_BITS   = PCM_BITS,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IDLE_CYCLES = 3_750_000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_i,
  input  logic                 mclk_i,
  input  logic                 dclk_i,
  input  logic                 fsync_i,
  input  logic                 sdata_i,
  output logic [WORD_BITS-1:0] word_o,
  output logic                 word_vld_o,
  output logic                 standby_o
);

  localparam int unsigned LINES = $bits(rx_lines_t);

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  rx_mode_e  mode;
  rx_lines_t raw_lines, lvl_s, rise_s, fall_s;
  logic      bclk_fall;
  logic      unused_edges;

  assign mode      = rx_mode_e'(mode_i);
  assign raw_lines = '{mclk: mclk_i, dclk: dclk_i, fs: fsync_i, sd: sdata_i};

  pcm_rx_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .raw_i  (raw_lines),
    .lvl_o  (lvl_s),
    .rise_o (rise_s),
    .fall_o (fall_s)
  );

  assign bclk_fall    = (mode == RX_VARIABLE) ? fall_s.dclk : fall_s.mclk;
  assign unused_edges = ^{lvl_s.mclk, lvl_s.dclk, rise_s.mclk, rise_s.dclk,
                          rise_s.sd, fall_s.sd, fall_s.fs};

  pcm_rx_idle #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .fs_lvl_i  (lvl_s.fs),
    .fs_rise_i (rise_s.fs),
    .standby_o (standby_o)
  );

  pcm_rx_shift #(.WORD_BITS(WORD_BITS)) u_shift (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .mode_i      (mode),
    .fs_lvl_i    (lvl_s.fs),
    .fs_rise_i   (rise_s.fs),
    .bclk_fall_i (bclk_fall),
    .sd_i        (lvl_s.sd),
    .standby_i   (standby_o),
    .word_o      (word_o),
    .vld_o       (word_vld_o)
  );

  // R10
  no_word_in_standby_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(standby_o) |-> !word_vld_o);

endmodule

// File: tb/pcm_rx_port_test.sv
module pcm_rx_port_test;

  localparam int IDLE = 300;
  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_i, mclk_i, dclk_i, fsync_i, sdata_i;
  logic [7:0] word_o;
  logic       word_vld_o, standby_o;

  int errors = 0;
  int checks = 0;
  int vld_cnt = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [7:0] last_word;

  always #4 clk = ~clk;

  pcm_rx_port #(.IDLE_CYCLES(IDLE)) uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .mclk_i(mclk_i),
    .dclk_i(dclk_i), .fsync_i(fsync_i), .sdata_i(sdata_i),
    .word_o(word_o), .word_vld_o(word_vld_o), .standby_o(standby_o)
  );

  always @(posedge clk) begin
    if (word_vld_o) vld_cnt <= vld_cnt + 1;
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one bit on the selected clock: sel 1 = dclk, 0 = mclk
  task automatic bit_on(input bit sel, input bit b);
    sdata_i = b;
    if (sel) dclk_i = 1'b1; else mclk_i = 1'b1;
    tick(HALF);
    if (sel) dclk_i = 1'b0; else mclk_i = 1'b0;
    tick(HALF);
  endtask

  task automatic send_fixed(input logic [7:0] w);
    fsync_i = 1'b1;
    tick(HALF);
    for (int i = 7; i >= 0; i--) begin
      bit_on(1'b0, w[i]);
      if (i == 6) fsync_i = 1'b0;
    end
    fsync_i = 1'b0;
    tick(6);
  endtask

  task automatic send_var(input logic [7:0] w, input int nbits);
    fsync_i = 1'b1;
    tick(HALF);
    for (int i = 7; i >= 8 - nbits; i--) bit_on(1'b1, w[i]);
    tick(HALF);
    fsync_i = 1'b0;
    tick(6);
  endtask

  localparam logic [8:0] VEC [6] = '{
    {1'b0, 8'hA5}, {1'b1, 8'h3C}, {1'b0, 8'h00},
    {1'b1, 8'hFF}, {1'b0, 8'h81}, {1'b1, 8'h7E}
  };

  initial begin
    int base;
    rst_n = 1'b0; mode_i = 1'b0; mclk_i = 1'b0; dclk_i = 1'b0;
    fsync_i = 1'b0; sdata_i = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    check(word_o == 8'h00, "R1 word after reset", word_o, 8'h00);
    check(word_vld_o == 1'b0, "R1 valid after reset", word_vld_o, 0);
    check(standby_o == 1'b0, "R1 standby after reset", standby_o, 0);

    // R2 / R4 / R5 table walk
    for (int v = 0; v < 6; v++) begin
      mode_i = VEC[v][8];
      base = vld_cnt;
      if (VEC[v][8]) send_var(VEC[v][7:0], 8);
      else           send_fixed(VEC[v][7:0]);
      check(word_o == VEC[v][7:0],
            VEC[v][8] ? "R5 variable word" : "R2 R4 fixed word", word_o, VEC[v][7:0]);
      check(vld_cnt - base == 1, "R3 one valid per word", vld_cnt - base, 1);
      last_word = VEC[v][7:0];
    end

    // R3 hold after word
    base = vld_cnt;
    tick(20);
    check(word_o == last_word && vld_cnt == base, "R3 word held", word_o, last_word);

    // R5 master clock ignored in variable mode
    mode_i = 1'b1;
    base = vld_cnt;
    fsync_i = 1'b1;
    tick(HALF);
    for (int i = 0; i < 8; i++) bit_on(1'b0, i[0]);
    check(vld_cnt == base, "R5 mclk ignored", vld_cnt - base, 0);
    fsync_i = 1'b0;
    tick(8);
    check(word_o == last_word, "R5 word kept", word_o, last_word);

    // R6 early close
    base = vld_cnt;
    send_var(8'hB4, 5);
    check(vld_cnt == base, "R6 no valid on short slot", vld_cnt - base, 0);
    check(word_o == last_word, "R6 word kept", word_o, last_word);
    send_var(8'h2D, 8);
    check(word_o == 8'h2D, "R6 next slot after abort", word_o, 8'h2D);
    last_word = 8'h2D;

    // R7 extra edges in a long slot
    base = vld_cnt;
    fsync_i = 1'b1;
    tick(HALF);
    for (int i = 7; i >= 0; i--) bit_on(1'b1, 8'h96 >> i);
    for (int i = 7; i >= 0; i--) bit_on(1'b1, 8'h11 >> i);
    fsync_i = 1'b0;
    tick(8);
    check(vld_cnt - base == 1, "R7 single valid per slot", vld_cnt - base, 1);
    check(word_o == 8'h96, "R7 first word kept", word_o, 8'h96);
    last_word = 8'h96;

    // R8 data clock ignored in fixed mode
    mode_i = 1'b0;
    base = vld_cnt;
    fsync_i = 1'b1;
    tick(HALF);
    fsync_i = 1'b0;
    for (int i = 0; i < 8; i++) bit_on(1'b1, 1'b1);
    check(vld_cnt == base, "R8 dclk ignored", vld_cnt - base, 0);
    for (int i = 7; i >= 0; i--) bit_on(1'b0, 8'hC3 >> i);
    tick(6);
    check(word_o == 8'hC3 && vld_cnt - base == 1, "R8 mclk word", word_o, 8'hC3);

    // R11 bit edge coinciding with sync rise is not a bit
    sdata_i = 1'b1;
    mclk_i = 1'b1;
    tick(HALF);
    fsync_i = 1'b1;
    mclk_i = 1'b0;
    tick(HALF);
    fsync_i = 1'b0;
    for (int i = 7; i >= 0; i--) bit_on(1'b0, 8'h5A >> i);
    tick(6);
    check(word_o == 8'h5A, "R11 coincident edge skipped", word_o, 8'h5A);
    last_word = 8'h5A;

    // R9 idle count restart, then standby
    tick(200);
    fsync_i = 1'b1;
    tick(4);
    fsync_i = 1'b0;
    tick(200);
    check(standby_o == 1'b0, "R9 count restarts on high sync", standby_o, 0);
    tick(120);
    check(standby_o == 1'b1, "R9 standby after idle limit", standby_o, 1);

    // R10 wake slot skipped, next slot captured
    mode_i = 1'b1;
    base = vld_cnt;
    send_var(8'hE7, 8);
    check(standby_o == 1'b0, "R10 standby cleared", standby_o, 0);
    check(vld_cnt == base, "R10 waking slot not captured", vld_cnt - base, 0);
    check(word_o == last_word, "R10 word unchanged", word_o, last_word);
    send_var(8'h42, 8);
    check(word_o == 8'h42 && vld_cnt - base == 1, "R10 next slot captured", word_o, 8'h42);

    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule